// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the device side of a 16-bit NOR flash bus and watches the write cycles the host issues. The write strobe is asynchronous to the block clock. The block synchronises it and treats each rising edge as one bus write, taking the address and data present on the bus at that moment. It follows the unlock-prefixed command sequences for word program, chip erase and sector erase. It also recognises the single-cycle suspend, resume and reset commands. When a command is complete and legal in the current operating state, it emits a one-cycle strobe carrying the operation kind, the captured address and the captured data to the embedded-operation engine.

The block also tracks the operating state: idle, programming, erasing the chip, erasing a sector, or erase suspended. From that state it reports which read mode the array port should use. The engine signals completion with `op_done`, which returns the block to array reads. A malformed sequence produces no strobe and drops the decoder back to its idle state.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `op_valid` is 0 and `rd_mode` is 0 (array read).
- R2: The writes AAh@555h, 55h@2AAh and A0h@555h, followed by any write, emit op_kind 1 (program) with that last write's address and data, but only when idle. `rd_mode` then becomes 1 (status/busy). Commands use data bits [7:0], and the unlock addresses are matched on address bits [10:0].
- R3: The writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh and 10h@555h emit op_kind 2 (chip erase) when idle.
- R4: The same five-write prefix as in R3, followed by 30h at any address, emits op_kind 3 (sector erase) with that address when idle.
- R5: A write that does not match the step expected in a sequence returns the decoder to idle without a strobe. Following writes are decoded as new sequences.
- R6: Erase suspend (B0h, any address, single cycle) is ignored unless a sector erase is running. It is ignored while idle and while a chip erase is running.
- R7: Erase suspend accepted during a sector erase emits op_kind 4, and `rd_mode` becomes 2 (erase-suspend read).
- R8: Erase resume (30h, any address, single cycle) emits op_kind 5 only in the suspended state, and `rd_mode` returns to 1. A resume in any other state, including a second resume, emits nothing.
- R9: `op_done` while programming or erasing returns `rd_mode` to 0. `op_done` while suspended has no effect.
- R10: F0h at any address, at any sequence step except the program data cycle, emits op_kind 6 (reset) and aborts the sequence in progress.
- R11: A complete program or erase sequence issued while an operation is running or suspended emits no strobe and leaves `rd_mode` unchanged.
- R12: `op_valid` is high for exactly one clock cycle. It rises on the third clock edge after the rising edge of `we_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| we_n | input | 1 | Asynchronous bus write strobe, active low; a write is taken on its rising edge |
| addr | input | 21 | Bus word address, stable around the strobe |
| data | input | 16 | Bus write data, stable around the strobe |
| op_done | input | 1 | Embedded operation finished (one-cycle pulse) |
| op_valid | output | 1 | One-cycle strobe for a decoded, accepted operation |
| op_kind | output | 3 | Operation kind: 1 program, 2 chip erase, 3 sector erase, 4 suspend, 5 resume, 6 reset |
| op_addr | output | 21 | Address captured with the final write of the operation |
| op_data | output | 16 | Data captured with the final write of the operation |
| rd_mode | output | 2 | 0 array read, 1 status (busy), 2 erase-suspend read |

## Verification
A rising `we_n` passes through two synchroniser flops and one edge flop. The strobe and the new `rd_mode` therefore appear after the third clock edge, and `op_done` takes effect after the first edge. Every write task drives the strobe at a falling clock edge. It then samples `op_valid` at the second falling edge, where the strobe must still be low, and again at the third, where any strobe must be high. It checks one cycle later that the strobe has dropped. Ignored commands are judged from both the missing strobe and an unchanged `rd_mode` at those same points.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam int ADDR_W  = 21;
    localparam int DATA_W  = 16;
    localparam int UNLK_W  = 11;

    localparam logic [7:0] CMD_UNLOCK_A = 8'hAA;
    localparam logic [7:0] CMD_UNLOCK_B = 8'h55;
    localparam logic [7:0] CMD_PROGRAM  = 8'hA0;
    localparam logic [7:0] CMD_ERASE    = 8'h80;
    localparam logic [7:0] CMD_CHIP     = 8'h10;
    localparam logic [7:0] CMD_SECTOR   = 8'h30;
    localparam logic [7:0] CMD_SUSPEND  = 8'hB0;
    localparam logic [7:0] CMD_RESET    = 8'hF0;

    localparam logic [UNLK_W-1:0] ADR_FIRST  = 11'h555;
    localparam logic [UNLK_W-1:0] ADR_SECOND = 11'h2AA;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_PROGRAM = 3'd1,
        OP_CHIP    = 3'd2,
        OP_SECTOR  = 3'd3,
        OP_SUSPEND = 3'd4,
        OP_RESUME  = 3'd5,
        OP_RESET   = 3'd6
    } op_kind_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_KEY1,
        SQ_CMD,
        SQ_PDATA,
        SQ_EKEY0,
        SQ_EKEY1,
        SQ_ECMD
    } seq_e;

    typedef enum logic [2:0] {
        MD_IDLE,
        MD_PROG,
        MD_CHIP,
        MD_SECTOR,
        MD_SUSP
    } mode_e;

    typedef enum logic [1:0] {
        RD_ARRAY  = 2'd0,
        RD_STATUS = 2'd1,
        RD_SUSP   = 2'd2
    } rd_mode_e;

    typedef struct packed {
        logic [UNLK_W-1:0] adr;
        logic [7:0]        cmd;
    } bus_wr_t;

    function automatic logic hit(bus_wr_t w, logic [UNLK_W-1:0] a, logic [7:0] c);
        return (w.adr == a) && (w.cmd == c);
    endfunction

    function automatic rd_mode_e mode_to_rd(mode_e m);
        case (m)
            MD_IDLE: return RD_ARRAY;
            MD_SUSP: return RD_SUSP;
            default: return RD_STATUS;
        endcase
    endfunction

endpackage

// File: rtl/wr_strobe_sync.sv
module wr_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_n,
    output logic wr_pulse
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain_q[i] <= 1'b1;
                else if (i == 0) chain_q[i] <= strobe_n;
                else chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b1;
        else     last_q <= chain_q[STAGES-1];
    end

    assign wr_pulse = chain_q[STAGES-1] & ~last_q;

    a_r12_pulse_single: assert property (@(posedge clk) disable iff (rst)
        wr_pulse |=> !wr_pulse);

endmodule

// File: rtl/cmd_seq.sv
module cmd_seq
    import flash_cmd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr,
    input  bus_wr_t  bw,
    output logic     req_valid,
    output op_kind_e req_kind
);
    seq_e state_q, state_d;

    always_comb begin
        state_d   = state_q;
        req_valid = 1'b0;
        req_kind  = OP_NONE;
        if (wr) begin
            state_d = SQ_IDLE;
            if (state_q != SQ_PDATA && bw.cmd == CMD_RESET) begin
                req_valid = 1'b1;
                req_kind  = OP_RESET;
            end else begin
                case (state_q)
                    SQ_IDLE: begin
                        if (hit(bw, ADR_FIRST, CMD_UNLOCK_A)) state_d = SQ_KEY1;
                        else if (bw.cmd == CMD_SUSPEND) begin
                            req_valid = 1'b1;
                            req_kind  = OP_SUSPEND;
                        end else if (bw.cmd == CMD_SECTOR) begin
                            req_valid = 1'b1;
                            req_kind  = OP_RESUME;
                        end
                    end
                    SQ_KEY1:
                        if (hit(bw, ADR_SECOND, CMD_UNLOCK_B)) state_d = SQ_CMD;
                    SQ_CMD:
                        if (hit(bw, ADR_FIRST, CMD_PROGRAM))    state_d = SQ_PDATA;
                        else if (hit(bw, ADR_FIRST, CMD_ERASE)) state_d = SQ_EKEY0;
                    SQ_PDATA: begin
                        req_valid = 1'b1;
                        req_kind  = OP_PROGRAM;
                    end
                    SQ_EKEY0:
                        if (hit(bw, ADR_FIRST, CMD_UNLOCK_A)) state_d = SQ_EKEY1;
                    SQ_EKEY1:
                        if (hit(bw, ADR_SECOND, CMD_UNLOCK_B)) state_d = SQ_ECMD;
                    SQ_ECMD:
                        if (hit(bw, ADR_FIRST, CMD_CHIP)) begin
                            req_valid = 1'b1;
                            req_kind  = OP_CHIP;
                        end else if (bw.cmd == CMD_SECTOR) begin
                            req_valid = 1'b1;
                            req_kind  = OP_SECTOR;
                        end
                    default: state_d = SQ_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SQ_IDLE;
        else     state_q <= state_d;
    end

    // R5: a bad second unlock write always lands back in idle
    a_r5_bad_key_idle: assert property (@(posedge clk) disable iff (rst)
        (wr && state_q == SQ_KEY1 && !(bw.adr == ADR_SECOND && bw.cmd == CMD_UNLOCK_B))
        |=> state_q == SQ_IDLE);

    // R10: reset outside the data cycle clears the sequence
    a_r10_reset_clears: assert property (@(posedge clk) disable iff (rst)
        (wr && state_q != SQ_PDATA && bw.cmd == CMD_RESET) |=> state_q == SQ_IDLE);

endmodule

// File: rtl/mode_track.sv
module mode_track
    import flash_cmd_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  op_kind_e      req_kind,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    input  logic          op_done,
    output logic          op_valid,
    output op_kind_e      op_kind,
    output logic [AW-1:0] op_addr,
    output logic [DW-1:0] op_data,
    output rd_mode_e      rd_mode
);
    mode_e mode_q, mode_d;
    logic  accept;
    logic  running;

    assign running = (mode_q == MD_PROG) || (mode_q == MD_CHIP) || (mode_q == MD_SECTOR);

    always_comb begin
        mode_d = mode_q;
        accept = 1'b0;
        if (running && op_done) begin
            mode_d = MD_IDLE;
        end else if (req_valid) begin
            case (req_kind)
                OP_PROGRAM: if (mode_q == MD_IDLE)   begin accept = 1'b1; mode_d = MD_PROG;   end
                OP_CHIP:    if (mode_q == MD_IDLE)   begin accept = 1'b1; mode_d = MD_CHIP;   end
                OP_SECTOR:  if (mode_q == MD_IDLE)   begin accept = 1'b1; mode_d = MD_SECTOR; end
                OP_SUSPEND: if (mode_q == MD_SECTOR) begin accept = 1'b1; mode_d = MD_SUSP;   end
                OP_RESUME:  if (mode_q == MD_SUSP)   begin accept = 1'b1; mode_d = MD_SECTOR; end
                OP_RESET:   accept = 1'b1;
                default:    accept = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= MD_IDLE;
            op_valid <= 1'b0;
            op_kind  <= OP_NONE;
            op_addr  <= '0;
            op_data  <= '0;
        end else begin
            mode_q   <= mode_d;
            op_valid <= accept;
            if (accept) begin
                op_kind <= req_kind;
                op_addr <= addr;
                op_data <= data;
            end
        end
    end

    assign rd_mode = mode_to_rd(mode_q);

    a_r2_prog_from_idle: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind == OP_PROGRAM) |-> ($past(mode_q) == MD_IDLE && mode_q == MD_PROG));

    a_r7_susp_from_sector: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind == OP_SUSPEND) |-> ($past(mode_q) == MD_SECTOR && rd_mode == RD_SUSP));

    a_r8_resume_from_susp: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind == OP_RESUME) |-> $past(mode_q) == MD_SUSP);

    a_r9_done_to_idle: assert property (@(posedge clk) disable iff (rst)
        (running && op_done) |=> rd_mode == RD_ARRAY);

    a_r9_susp_holds: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MD_SUSP && !req_valid) |=> mode_q == MD_SUSP);

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    input  logic              op_done,
    output logic              op_valid,
    output logic [2:0]        op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data,
    output logic [1:0]        rd_mode
);
    localparam int SYNC_STAGES = 2;

    logic     wr;
    bus_wr_t  bw;
    logic     req_valid;
    op_kind_e req_kind;
    op_kind_e kind_q;
    rd_mode_e rd_q;

    assign bw.adr = addr[UNLK_W-1:0];
    assign bw.cmd = data[7:0];

    wr_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .strobe_n (we_n),
        .wr_pulse (wr)
    );

    cmd_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr),
        .bw        (bw),
        .req_valid (req_valid),
        .req_kind  (req_kind)
    );

    mode_track #(.AW(ADDR_W), .DW(DATA_W)) u_mode (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .addr      (addr),
        .data      (data),
        .op_done   (op_done),
        .op_valid  (op_valid),
        .op_kind   (kind_q),
        .op_addr   (op_addr),
        .op_data   (op_data),
        .rd_mode   (rd_q)
    );

    assign op_kind = kind_q;
    assign rd_mode = rd_q;

    a_r12_one_cycle: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> !op_valid);

    a_r12_needs_write: assert property (@(posedge clk) disable iff (rst)
        op_valid |-> $past(wr));

endmodule

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we_n = 1'b1;
    logic [20:0] addr = '0;
    logic [15:0] data = '0;
    logic        op_done = 1'b0;
    logic        op_valid;
    logic [2:0]  op_kind;
    logic [20:0] op_addr;
    logic [15:0] op_data;
    logic [1:0]  rd_mode;

    int checks = 0;
    int errors = 0;

    logic        got_v;
    logic [2:0]  got_k;
    logic [20:0] got_a;
    logic [15:0] got_d;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_decoder u0 (
        .clk(clk), .rst(rst), .we_n(we_n), .addr(addr), .data(data),
        .op_done(op_done), .op_valid(op_valid), .op_kind(op_kind),
        .op_addr(op_addr), .op_data(op_data), .rd_mode(rd_mode)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one bus write; result is the strobe seen at the due cycle (R12)
    task automatic bus_write(input logic [20:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; data = d; we_n = 1'b0;
        repeat (2) @(negedge clk);
        we_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!op_valid, "R12 early", int'(op_valid), 0);
        @(negedge clk);
        got_v = op_valid; got_k = op_kind; got_a = op_addr; got_d = op_data;
        @(negedge clk);
        check(!op_valid, "R12 width", int'(op_valid), 0);
    endtask

    task automatic expect_none(input string req);
        check(!got_v, req, int'(got_v), 0);
    endtask

    task automatic expect_op(input string req, input int k);
        check(got_v && got_k == 3'(k), req, int'(got_k), k);
    endtask

    task automatic expect_rd(input string req, input int m);
        check(rd_mode == 2'(m), req, int'(rd_mode), m);
    endtask

    task automatic unlock();
        bus_write(21'h555, 16'h00AA); expect_none("R5 unlock1");
        bus_write(21'h2AA, 16'h0055); expect_none("R5 unlock2");
    endtask

    task automatic erase_prefix();
        unlock();
        bus_write(21'h555, 16'h0080);
        unlock();
    endtask

    task automatic pulse_done();
        @(negedge clk); op_done = 1'b1;
        @(negedge clk); op_done = 1'b0;
    endtask

    task automatic t_reset();
        check(!op_valid, "R1 op_valid", int'(op_valid), 0);
        expect_rd("R1 rd_mode", 0);
    endtask

    task automatic t_program();
        unlock();
        bus_write(21'h1FD55, 16'h00A0); expect_none("R2 setup");
        bus_write(21'h1ABCD, 16'h5A3C);
        expect_op("R2 kind", 1);
        check(got_a == 21'h1ABCD, "R2 addr", int'(got_a), 'h1ABCD);
        check(got_d == 16'h5A3C, "R2 data", int'(got_d), 'h5A3C);
        expect_rd("R2 busy", 1);
        unlock(); bus_write(21'h555, 16'h00A0); bus_write(21'h00010, 16'h1111);
        expect_none("R11 program while busy");
        expect_rd("R11 mode kept", 1);
        pulse_done();
        expect_rd("R9 done", 0);
    endtask

    task automatic t_chip();
        erase_prefix();
        bus_write(21'h555, 16'h0010);
        expect_op("R3 chip", 2);
        expect_rd("R3 busy", 1);
        bus_write(21'h00100, 16'h00B0);
        expect_none("R6 suspend in chip erase");
        expect_rd("R6 mode kept", 1);
        pulse_done();
        expect_rd("R9 chip done", 0);
    endtask

    task automatic t_sector();
        erase_prefix();
        bus_write(21'h0C123, 16'h0030);
        expect_op("R4 sector", 3);
        check(got_a == 21'h0C123, "R4 addr", int'(got_a), 'h0C123);
        bus_write(21'h00000, 16'h0030);
        expect_none("R8 resume while running");
        bus_write(21'h12345, 16'h00B0);
        expect_op("R7 suspend", 4);
        expect_rd("R7 suspend read", 2);
        pulse_done();
        expect_rd("R9 done ignored in suspend", 2);
        erase_prefix(); bus_write(21'h555, 16'h0010);
        expect_none("R11 erase while suspended");
        expect_rd("R11 still suspended", 2);
        bus_write(21'h00777, 16'h0030);
        expect_op("R8 resume", 5);
        expect_rd("R8 busy again", 1);
        bus_write(21'h00777, 16'h0030);
        expect_none("R8 second resume");
        pulse_done();
        expect_rd("R9 sector done", 0);
    endtask

    task automatic t_mismatch();
        bus_write(21'h555, 16'h00AA);
        bus_write(21'h2AA, 16'h0056); expect_none("R5 bad key");
        bus_write(21'h555, 16'h00A0); expect_none("R5 no setup");
        bus_write(21'h00100, 16'h1234); expect_none("R5 no program");
        expect_rd("R5 idle", 0);
        bus_write(21'h554, 16'h00AA);
        bus_write(21'h2AA, 16'h0055);
        bus_write(21'h555, 16'h0080);
        expect_none("R5 bad address");
        bus_write(21'h00040, 16'h00B0);
        expect_none("R6 suspend idle");
        expect_rd("R6 idle kept", 0);
        unlock(); bus_write(21'h555, 16'h00A0); bus_write(21'h00020, 16'h0F0F);
        expect_op("R5 fresh sequence", 1);
        pulse_done();
    endtask

    task automatic t_reset_cmd();
        unlock();
        bus_write(21'h00123, 16'h00F0);
        expect_op("R10 reset", 6);
        bus_write(21'h00200, 16'h1111);
        expect_none("R10 aborted");
        erase_prefix();
        bus_write(21'h00999, 16'h00F0);
        expect_op("R10 reset in erase", 6);
        bus_write(21'h555, 16'h0010);
        expect_none("R10 erase aborted");
        expect_rd("R10 array", 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_program();
        t_chip();
        t_sector();
        t_mismatch();
        t_reset_cmd();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule